// File: doc/BRIEF.md
# UART Receive Holding Queue with Break Insertion

This block sits between a UART's bit deserializer and the host register interface. Completed bytes from the line side enter a small first-in, first-out store of four entries. The host removes them one at a time by strobing a pop, which happens on each read of the data register. Two status flags follow the store's occupancy: a "data available" flag and a "store full" flag. A ready output tells the deserializer when a normal byte would be taken.

A line break is treated differently from a normal byte. It always enters the store as a zero byte, whether or not the receiver is enabled and whether or not the store is full. When the store is full, the zero byte takes the place of the newest entry, so the three oldest bytes survive. Each break also raises a sticky break-change flag. Only an explicit clear strobe from the command decoder lowers that flag.

The receiver enable is a state bit driven by on and off strobes from the command decoder. A receiver-reset strobe switches the receiver off, empties the store and drops both occupancy flags.

Top module: `rx_hold_fifo`

## Requirements
- R1: Bytes leave the store in the order they entered. `rd_data` always shows the oldest stored byte, and the store holds at most four bytes.
- R2: A byte on `rx_valid`/`rx_data` is stored only when the receiver is enabled and `full_flag` is low. `line_ready` equals (enabled AND NOT full_flag). A byte offered while `line_ready` is low is dropped.
- R3: A `brk_evt` pulse stores a byte of value 0x00 and sets `brk_flag` on the next clock, whether or not the receiver is enabled.
- R4: A `brk_evt` while four bytes are held, with no pop in the same cycle, overwrites the newest entry with 0x00. The count stays at four.
- R5: `rdy_flag` is high whenever at least one byte is held. It is set by any push. `full_flag` is high exactly when four bytes are held.
- R6: A `pop_req` while the store is empty shows `rd_data` = 0x00 and changes no state.
- R7: A `pop_req` on a non-empty store removes the oldest byte and clears `full_flag`. When the last byte is removed, it also clears `rdy_flag`.
- R8: A push and a pop in the same cycle on a non-empty store are both applied, and the count is unchanged. With four bytes held, a break plus a pop drops the oldest byte and appends 0x00.
- R9: `rcv_reset` disables the receiver, empties the store and clears `rdy_flag` and `full_flag`. It overrides every other input in the same cycle except the break flag update.
- R10: `brk_flag` stays set until a `brk_clr` strobe. If a break and a clear arrive in the same cycle, the flag stays set.
- R11: `rcv_on` enables the receiver and `rcv_off` disables it. If both arrive together, the receiver is disabled.
- R12: If a break and a normal byte arrive in the same cycle, only the 0x00 break byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Deserializer offers a byte this cycle |
| rx_data | input | 8 | Offered byte |
| brk_evt | input | 1 | Line break detected (one-cycle pulse) |
| rcv_on | input | 1 | Enable receiver strobe |
| rcv_off | input | 1 | Disable receiver strobe |
| rcv_reset | input | 1 | Receiver reset strobe |
| brk_clr | input | 1 | Clear break-change flag strobe |
| pop_req | input | 1 | Host read of the data register |
| rd_data | output | 8 | Oldest byte, or 0x00 when empty |
| rdy_flag | output | 1 | At least one byte held |
| full_flag | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break-change flag |
| line_ready | output | 1 | A normal byte would be accepted |

## Verification
The store is filled in order and then drained to check ordering and the flag edges. It is filled to four to show that ordinary data bounces off a full store while a break overwrites the newest slot. Same-cycle combinations separate the priority rules: push with pop, break with data, break with pop on a full store, on with off, and reset with data and enable. A long random phase mixes all strobes, and a queue model checks every output on every clock. This catches pointer wrap and count errors that the directed cases would not reach.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_BYTE_W = 8;
    localparam int unsigned RXQ_DEPTH  = 4;

    // Per-cycle operation applied to the storage array.
    typedef struct packed {
        logic pop;    // remove the oldest entry
        logic push;   // append at the tail
        logic over;   // overwrite the newest entry in place
    } rxq_op_t;

    typedef enum logic [1:0] {
        EN_HOLD = 2'd0,
        EN_SET  = 2'd1,
        EN_CLR  = 2'd2
    } rxq_en_cmd_t;

    // Decode the enable strobes; disabling wins over enabling.
    function automatic rxq_en_cmd_t rxq_en_decode(input logic on, input logic off, input logic rst_rcv);
        if (rst_rcv || off) return EN_CLR;
        if (on)             return EN_SET;
        return EN_HOLD;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = RXQ_BYTE_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  rxq_op_t                       op,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     head_q;
    logic [CW-1:0]     cnt_q;
    logic [PW-1:0]     tail_idx;
    logic [PW-1:0]     newest_idx;

    function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] base, input int unsigned off);
        int unsigned s;
        s = (int'(base) + off) % DEPTH;
        return PW'(s);
    endfunction

    always_comb begin
        tail_idx   = ptr_add(head_q, int'(cnt_q));
        newest_idx = ptr_add(head_q, int'(cnt_q) + DEPTH - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (op.pop) head_q <= ptr_add(head_q, 1);
            if (op.push && !op.pop)      cnt_q <= cnt_q + CW'(1);
            else if (op.pop && !op.push) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush) begin
            if (op.push)      mem[tail_idx]   <= wdata;
            else if (op.over) mem[newest_idx] <= wdata;
        end
    end

    assign head_data = mem[head_q];
    assign count     = cnt_q;

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = RXQ_BYTE_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       enabled,
    input  logic                       rcv_reset,
    input  logic                       rx_valid,
    input  logic [DATA_W-1:0]          rx_data,
    input  logic                       brk_evt,
    input  logic                       pop_req,
    output rxq_op_t                    op,
    output logic [DATA_W-1:0]          wdata,
    output logic                       line_ready
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic is_full, is_empty, pop_ok, take_data;

    always_comb begin
        is_full    = (count == CW'(DEPTH));
        is_empty   = (count == '0);
        line_ready = enabled && !is_full;
        pop_ok     = pop_req && !is_empty && !rcv_reset;
        take_data  = rx_valid && line_ready && !brk_evt && !rcv_reset;

        op.pop  = pop_ok;
        op.push = take_data || (brk_evt && !rcv_reset && (!is_full || pop_ok));
        op.over = brk_evt && !rcv_reset && is_full && !pop_ok;
        wdata   = brk_evt ? '0 : rx_data;
    end

endmodule

// File: rtl/rxq_state.sv
module rxq_state
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rcv_on,
    input  logic rcv_off,
    input  logic rcv_reset,
    input  logic brk_evt,
    input  logic brk_clr,
    output logic enabled,
    output logic brk_flag
);
    rxq_en_cmd_t en_cmd;

    assign en_cmd = rxq_en_decode(rcv_on, rcv_off, rcv_reset);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled  <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            case (en_cmd)
                EN_SET:  enabled <= 1'b1;
                EN_CLR:  enabled <= 1'b0;
                default: enabled <= enabled;
            endcase
            if (brk_evt)      brk_flag <= 1'b1;
            else if (brk_clr) brk_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = RXQ_BYTE_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              brk_evt,
    input  logic              rcv_on,
    input  logic              rcv_off,
    input  logic              rcv_reset,
    input  logic              brk_clr,
    input  logic              pop_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy_flag,
    output logic              full_flag,
    output logic              brk_flag,
    output logic              line_ready
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rxq_op_t           op;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] head_data;
    logic [CW-1:0]     count;
    logic              enabled;

    rxq_state u_state (
        .clk       (clk),
        .rst       (rst),
        .rcv_on    (rcv_on),
        .rcv_off   (rcv_off),
        .rcv_reset (rcv_reset),
        .brk_evt   (brk_evt),
        .brk_clr   (brk_clr),
        .enabled   (enabled),
        .brk_flag  (brk_flag)
    );

    rxq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .count      (count),
        .enabled    (enabled),
        .rcv_reset  (rcv_reset),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .brk_evt    (brk_evt),
        .pop_req    (pop_req),
        .op         (op),
        .wdata      (wdata),
        .line_ready (line_ready)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (rcv_reset),
        .op        (op),
        .wdata     (wdata),
        .head_data (head_data),
        .count     (count)
    );

    assign rdy_flag  = (count != '0);
    assign full_flag = (count == CW'(DEPTH));
    assign rd_data   = rdy_flag ? head_data : '0;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              brk_evt,
    input logic              brk_clr,
    input logic              rcv_reset,
    input logic              pop_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy_flag,
    input logic              full_flag,
    input logic              brk_flag,
    input logic              line_ready
);
    p_full_has_data_r5: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> rdy_flag);

    p_no_accept_full_r2: assert property (@(posedge clk) disable iff (rst)
        line_ready |-> !full_flag);

    p_break_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> brk_flag);

    p_break_keeps_full_r4: assert property (@(posedge clk) disable iff (rst)
        (full_flag && brk_evt && !pop_req && !rcv_reset) |=> full_flag);

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!rdy_flag && pop_req) |-> (rd_data == '0));

    p_rcv_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
        rcv_reset |=> (!rdy_flag && !full_flag && !line_ready));

    p_brk_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (brk_flag && !brk_clr) |=> brk_flag);

    p_brk_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        (brk_clr && !brk_evt) |=> !brk_flag);
endmodule

bind rx_hold_fifo rxq_checker #(.DATA_W(DATA_W)) u_rxq_checker (
    .clk        (clk),
    .rst        (rst),
    .brk_evt    (brk_evt),
    .brk_clr    (brk_clr),
    .rcv_reset  (rcv_reset),
    .pop_req    (pop_req),
    .rd_data    (rd_data),
    .rdy_flag   (rdy_flag),
    .full_flag  (full_flag),
    .brk_flag   (brk_flag),
    .line_ready (line_ready)
);

// File: tb/tb_rx_hold_fifo.sv
module tb_rx_hold_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 0, brk_evt = 0, rcv_on = 0, rcv_off = 0;
    logic       rcv_reset = 0, brk_clr = 0, pop_req = 0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] rd_data;
    logic       rdy_flag, full_flag, brk_flag, line_ready;

    always #4 clk = ~clk;   // 125 MHz

    rx_hold_fifo dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .brk_evt(brk_evt), .rcv_on(rcv_on), .rcv_off(rcv_off),
        .rcv_reset(rcv_reset), .brk_clr(brk_clr), .pop_req(pop_req),
        .rd_data(rd_data), .rdy_flag(rdy_flag), .full_flag(full_flag),
        .brk_flag(brk_flag), .line_ready(line_ready)
    );

    // Behavioural reference
    byte unsigned mq[$];
    bit           m_en, m_brk;
    int           checks = 0, fails = 0, cycles = 0;
    bit           done = 0;
    logic [7:0]   last_rd;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_head();
        return (mq.size() != 0) ? int'(mq[0]) : 0;
    endfunction

    task automatic model_step();
        bit full_before = (mq.size() == 4);
        bit en_before   = m_en;
        if (brk_evt) m_brk = 1;
        else if (brk_clr) m_brk = 0;
        if (rcv_reset) begin
            mq.delete();
            m_en = 0;
        end else begin
            if (pop_req && mq.size() != 0) void'(mq.pop_front());
            if (brk_evt) begin
                if (mq.size() == 4) mq[3] = 8'h00;
                else mq.push_back(8'h00);
            end else if (rx_valid && en_before && !full_before) begin
                mq.push_back(rx_data);
            end
            if (rcv_off) m_en = 0;
            else if (rcv_on) m_en = 1;
        end
    endtask

    task automatic cmp_flags();
        chk(rdy_flag == (mq.size() != 0), "R5 rdy_flag", rdy_flag, mq.size() != 0);
        chk(full_flag == (mq.size() == 4), "R5 full_flag", full_flag, mq.size() == 4);
        chk(line_ready == (m_en && mq.size() < 4), "R2 line_ready", line_ready, m_en && mq.size() < 4);
        chk(brk_flag == m_brk, "R10 brk_flag", brk_flag, m_brk);
    endtask

    // One clock: drive after negedge, check data, clock, update model, check flags.
    task automatic cyc(input bit v, input byte unsigned d, input bit b, input bit p,
                       input bit on, input bit off, input bit rr, input bit bc);
        rx_valid = v; rx_data = d; brk_evt = b; pop_req = p;
        rcv_on = on; rcv_off = off; rcv_reset = rr; brk_clr = bc;
        #1;
        last_rd = rd_data;
        chk(int'(rd_data) == exp_head(), "R1 rd_data", rd_data, exp_head());
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp_flags();
    endtask

    task automatic idle();            cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic send(input byte unsigned d); cyc(1, d, 0, 0, 0, 0, 0, 0); endtask
    task automatic pop_expect(input byte unsigned e, input string tag);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk(last_rd == e, tag, last_rd, e);
    endtask

    initial begin : watchdog
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state (R9 clears everything)
        chk(rdy_flag == 0 && full_flag == 0 && brk_flag == 0 && line_ready == 0,
            "R9 reset state", {rdy_flag, full_flag, brk_flag, line_ready}, 0);
        // R6: pop on empty returns 0, no change
        pop_expect(8'h00, "R6 empty pop");
        chk(rdy_flag == 0, "R6 state unchanged", rdy_flag, 0);
        // R2: data while disabled is dropped
        send(8'h11);
        chk(rdy_flag == 0, "R2 disabled drop", rdy_flag, 0);
        // R11: enable
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk(line_ready == 1, "R11 enable", line_ready, 1);
        send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
        chk(full_flag == 1, "R5 full at four", full_flag, 1);
        send(8'h55);   // R2: dropped while full
        // R4 / R3: break on full overwrites newest
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        chk(full_flag == 1 && brk_flag == 1, "R4 break on full", {full_flag, brk_flag}, 3);
        pop_expect(8'hA1, "R7 pop oldest");
        chk(full_flag == 0, "R7 full cleared", full_flag, 0);
        pop_expect(8'hA2, "R1 order");
        pop_expect(8'hA3, "R1 order");
        pop_expect(8'h00, "R4 newest replaced by zero");
        chk(rdy_flag == 0, "R7 rdy cleared at empty", rdy_flag, 0);
        // R10: clear break flag
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk(brk_flag == 0, "R10 clear", brk_flag, 0);
        // R10: break and clear together -> stays set
        cyc(0, 0, 1, 0, 0, 0, 0, 1);
        chk(brk_flag == 1, "R10 set wins", brk_flag, 1);
        pop_expect(8'h00, "R3 break byte");
        // R8: simultaneous push and pop
        send(8'hB1); send(8'hB2);
        cyc(1, 8'hB3, 0, 1, 0, 0, 0, 0);
        chk(last_rd == 8'hB1, "R8 pop during push", last_rd, 8'hB1);
        pop_expect(8'hB2, "R8 count kept");
        pop_expect(8'hB3, "R8 pushed byte");
        chk(rdy_flag == 0, "R8 drained", rdy_flag, 0);
        // R12: break and data together
        cyc(1, 8'hC7, 1, 0, 0, 0, 0, 0);
        pop_expect(8'h00, "R12 break wins");
        chk(rdy_flag == 0, "R12 data dropped", rdy_flag, 0);
        // R8: full + break + pop
        send(8'hD1); send(8'hD2); send(8'hD3); send(8'hD4);
        cyc(0, 0, 1, 1, 0, 0, 0, 0);
        chk(last_rd == 8'hD1 && full_flag == 1, "R8 full break pop", last_rd, 8'hD1);
        pop_expect(8'hD2, "R8 order");
        pop_expect(8'hD3, "R8 order");
        pop_expect(8'hD4, "R8 order");
        pop_expect(8'h00, "R8 appended zero");
        // R11: on and off together -> disabled
        cyc(0, 0, 0, 0, 1, 1, 0, 0);
        chk(line_ready == 0, "R11 off wins", line_ready, 0);
        // R3: break while disabled still stored
        cyc(0, 0, 1, 0, 0, 0, 0, 0);
        chk(rdy_flag == 1, "R3 break while disabled", rdy_flag, 1);
        // R9: reset with data held, enable and data same cycle
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        send(8'hE1);
        cyc(1, 8'hE2, 0, 0, 1, 0, 1, 0);
        chk(rdy_flag == 0 && line_ready == 0 && brk_flag == 1, "R9 rcv reset",
            {rdy_flag, line_ready, brk_flag}, 1);
        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            cyc($urandom_range(0, 1) == 1, byte'($urandom_range(1, 255)),
                r < 6, $urandom_range(0, 2) == 0,
                r >= 90, (r >= 6 && r < 9), r == 50, (r >= 60 && r < 64));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule